// File: doc/BRIEF.md
# Inter-processor and timer interrupt unit

This block holds, for each of up to four CPUs, one pending flag for an inter-processor interrupt and one for an interval-timer interrupt. Each flag drives a level output toward its CPU. Software raises and drops the flags through a small register window. A shared control register carries three packed per-CPU fields, so a single write can post IPIs, drop IPIs and drop timer interrupts at once. Three dedicated registers post IPIs, and drop IPIs or timer interrupts, from the low bits of the written word. A timer tick input marks a timer interrupt pending on every CPU.

Register accesses arrive as single-cycle strobes. There is no back-pressure: an access is taken in every cycle that `acc_valid` is high. A read returns its data exactly one cycle later with `rd_valid`. Three one-cycle pulse outputs report misuse:
- a redundant post or drop of an IPI,
- a dedicated-register write whose CPU selection is empty,
- a control write that carries nothing the block recognises.

Register index on `acc_addr`: 0 is the control register, 1 posts IPIs, 2 holds IPI status, 3 holds timer status.

Top module: `ipt_unit`

## Requirements
- R1: After reset, every IPI and timer pending flag is zero, and `warn_pulse`, `err_pulse`, `unsup_pulse` and `rd_valid` are low.
- R2: A control write (index 0) applies its three fields in the same write: bits [15:12] post an IPI per CPU, bits [11:8] drop an IPI per CPU, and bits [7:4] drop a timer interrupt per CPU. Bit n of each field selects CPU n. If one CPU is both posted and dropped in the same write, the drop is applied after the post, so that CPU ends with no IPI pending. The new state is visible on the outputs in the cycle after the write.
- R3: Posting an IPI to a CPU that already has one pending, or dropping an IPI that is not pending (judged after any post in the same write), leaves that flag as it is. Either case gives a one-cycle `warn_pulse` in the cycle after the write.
- R4: A `tick` sets every CPU's timer flag in the next cycle. When a timer drop arrives in the same cycle as a tick, the tick wins and all timer flags end up set.
- R5: A timer drop clears only CPUs that are both selected and pending. Dropping a timer interrupt that is not pending gives no warning.
- R6: A control write gives a one-cycle `unsup_pulse` when all three fields select no CPU and bit 28 is clear. If bit 28 is set, the write is accepted silently.
- R7: A write to index 1 posts IPIs to the CPUs selected by bits [NCPU-1:0]. A write to index 2 drops IPIs, and a write to index 3 drops timer interrupts, for the CPUs selected by those same bits.
- R8: A write to index 1, 2 or 3 whose effective selection is empty gives a one-cycle `err_pulse` and changes no state.
- R9: A read gives `rd_valid` one cycle later. The data is:
  - index 0: `acc_cpu` in bits [1:0], all other bits zero;
  - index 1: zero;
  - index 2: the IPI flags in bits [NCPU-1:0];
  - index 3: the timer flags in bits [NCPU-1:0].
- R10: Selection bits for CPUs at or above NCPU are ignored everywhere. A selection that only names such CPUs counts as empty.
- R11: `ipi_irq` and `tmr_irq` are levels equal to the pending flags that the status reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, taken every cycle it is high |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register index |
| acc_wdata | input | DW | Write data |
| acc_cpu | input | 2 | Id of the CPU making the access |
| tick | input | 1 | Interval-timer tick |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DW | Read data |
| ipi_irq | output | NCPU | Per-CPU IPI level |
| tmr_irq | output | NCPU | Per-CPU timer interrupt level |
| warn_pulse | output | 1 | Redundant IPI post or drop |
| err_pulse | output | 1 | Dedicated write with empty selection |
| unsup_pulse | output | 1 | Control write with no recognised field |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a timer tick and a timer drop. The bench writes the timer status register, or a control word with bits [7:4] set, in the very cycle it raises `tick`. It expects every timer flag to be set afterwards.

The second pair is the post and drop of an IPI for the same CPU within one control word. The bench expects the drop to win. It also expects the warning to be judged on the state as it stands after the post.

A behavioural reference model in the bench follows both orderings. It is compared with every output on every clock, including during a long run of random accesses that overlap ticks.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_IPI_SET  = 2'd1,
    REG_IPI_STAT = 2'd2,
    REG_TMR_STAT = 2'd3
  } reg_sel_e;

  localparam int FIELD_W    = 4;
  localparam int POST_LSB   = 12;
  localparam int IDROP_LSB  = 8;
  localparam int TDROP_LSB  = 4;
  localparam int ACCEPT_BIT = 28;

  typedef struct packed {
    logic [FIELD_W-1:0] ipi_post;
    logic [FIELD_W-1:0] ipi_drop;
    logic [FIELD_W-1:0] tmr_drop;
  } op_t;
endpackage

// File: rtl/ipt_decode.sv
module ipt_decode
  import ipt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output op_t           op,
  output logic          empty_err,
  output logic          unsup
);
  localparam logic [FIELD_W-1:0] CPU_MASK = FIELD_W'((1 << NCPU) - 1);

  logic               wr;
  logic [FIELD_W-1:0] low_sel;

  assign wr      = acc_valid && acc_write;
  assign low_sel = acc_wdata[FIELD_W-1:0] & CPU_MASK;

  always_comb begin
    op        = '0;
    empty_err = 1'b0;
    unsup     = 1'b0;
    if (wr) begin
      unique case (reg_sel_e'(acc_addr))
        REG_CTRL: begin
          op.ipi_post = acc_wdata[POST_LSB  +: FIELD_W] & CPU_MASK;
          op.ipi_drop = acc_wdata[IDROP_LSB +: FIELD_W] & CPU_MASK;
          op.tmr_drop = acc_wdata[TDROP_LSB +: FIELD_W] & CPU_MASK;
          unsup = (op == '0) && !acc_wdata[ACCEPT_BIT];
        end
        REG_IPI_SET: begin
          op.ipi_post = low_sel;
          empty_err   = (low_sel == '0);
        end
        REG_IPI_STAT: begin
          op.ipi_drop = low_sel;
          empty_err   = (low_sel == '0);
        end
        REG_TMR_STAT: begin
          op.tmr_drop = low_sel;
          empty_err   = (low_sel == '0);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipt_ipi_bank.sv
module ipt_ipi_bank #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] post_sel,
  input  logic [NCPU-1:0] drop_sel,
  output logic [NCPU-1:0] pend,
  output logic            warn
);
  logic [NCPU-1:0] redundant;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic after_post;
    assign after_post   = pend[g] | post_sel[g];
    assign redundant[g] = (post_sel[g] & pend[g]) | (drop_sel[g] & ~after_post);

    always_ff @(posedge clk) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= after_post & ~drop_sel[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) warn <= 1'b0;
    else        warn <= |redundant;
  end
endmodule

// File: rtl/ipt_tmr_bank.sv
module ipt_tmr_bank #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NCPU-1:0] drop_sel,
  output logic [NCPU-1:0] pend
);
  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n)    pend[g] <= 1'b0;
      else if (tick) pend[g] <= 1'b1;
      else           pend[g] <= pend[g] & ~drop_sel[g];
    end
  end
endmodule

// File: rtl/ipt_rd_port.sv
module ipt_rd_port
  import ipt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_addr,
  input  logic [1:0]      acc_cpu,
  input  logic [NCPU-1:0] ipi_pend,
  input  logic [NCPU-1:0] tmr_pend,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  logic [DW-1:0] sel_data;

  always_comb begin
    unique case (reg_sel_e'(acc_addr))
      REG_CTRL:     sel_data = DW'(acc_cpu);
      REG_IPI_STAT: sel_data = DW'(ipi_pend);
      REG_TMR_STAT: sel_data = DW'(tmr_pend);
      default:      sel_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      rd_data  <= (acc_valid && !acc_write) ? sel_data : '0;
    end
  end
endmodule

// File: rtl/ipt_unit.sv
module ipt_unit
  import ipt_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  input  logic [1:0]      acc_cpu,
  input  logic            tick,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic            warn_pulse,
  output logic            err_pulse,
  output logic            unsup_pulse
);
  op_t  op;
  logic empty_err;
  logic unsup;

  ipt_decode #(.NCPU(NCPU), .DW(DW)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .op        (op),
    .empty_err (empty_err),
    .unsup     (unsup)
  );

  ipt_ipi_bank #(.NCPU(NCPU)) u_ipi (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_sel (op.ipi_post[NCPU-1:0]),
    .drop_sel (op.ipi_drop[NCPU-1:0]),
    .pend     (ipi_irq),
    .warn     (warn_pulse)
  );

  ipt_tmr_bank #(.NCPU(NCPU)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .drop_sel (op.tmr_drop[NCPU-1:0]),
    .pend     (tmr_irq)
  );

  ipt_rd_port #(.NCPU(NCPU), .DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_cpu   (acc_cpu),
    .ipi_pend  (ipi_irq),
    .tmr_pend  (tmr_irq),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse   <= 1'b0;
      unsup_pulse <= 1'b0;
    end else begin
      err_pulse   <= empty_err;
      unsup_pulse <= unsup;
    end
  end
endmodule

// File: rtl/ipt_unit_chk.sv
module ipt_unit_chk #(
  parameter int NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [1:0]      acc_addr,
  input logic            tick,
  input logic            rd_valid,
  input logic [NCPU-1:0] ipi_irq,
  input logic [NCPU-1:0] tmr_irq,
  input logic            warn_pulse,
  input logic            err_pulse,
  input logic            unsup_pulse
);
  assert_tick_sets_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (&tmr_irq));

  assert_ipi_rise_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ipi_irq & ~$past(ipi_irq))) |->
      $past(acc_valid && acc_write && (acc_addr == 2'd0 || acc_addr == 2'd1)));

  assert_tmr_fall_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(tmr_irq) & ~tmr_irq)) |->
      $past(acc_valid && acc_write && !tick && (acc_addr == 2'd0 || acc_addr == 2'd3)));

  assert_unsup_from_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_pulse |-> $past(acc_valid && acc_write && acc_addr == 2'd0));

  assert_err_from_dedicated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(acc_valid && acc_write && acc_addr != 2'd0));

  assert_err_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (ipi_irq == $past(ipi_irq)));

  assert_warn_from_ipi_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> $past(acc_valid && acc_write && acc_addr != 2'd3));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write));
endmodule

bind ipt_unit ipt_unit_chk #(.NCPU(NCPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .tick        (tick),
  .rd_valid    (rd_valid),
  .ipi_irq     (ipi_irq),
  .tmr_irq     (tmr_irq),
  .warn_pulse  (warn_pulse),
  .err_pulse   (err_pulse),
  .unsup_pulse (unsup_pulse)
);

// File: tb/sim_ipt_unit.sv
module sim_ipt_unit;
  localparam int NCPU = 3;
  localparam int DW   = 32;
  localparam int VM   = (1 << NCPU) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc_valid = 1'b0;
  logic            acc_write = 1'b0;
  logic [1:0]      acc_addr = '0;
  logic [DW-1:0]   acc_wdata = '0;
  logic [1:0]      acc_cpu = '0;
  logic            tick = 1'b0;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic [NCPU-1:0] ipi_irq;
  logic [NCPU-1:0] tmr_irq;
  logic            warn_pulse;
  logic            err_pulse;
  logic            unsup_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ipt_unit #(.NCPU(NCPU), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu), .tick(tick),
    .rd_valid(rd_valid), .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .warn_pulse(warn_pulse), .err_pulse(err_pulse), .unsup_pulse(unsup_pulse)
  );

  // reference model state
  int m_ipi = 0, m_tmr = 0;
  int m_warn = 0, m_err = 0, m_unsup = 0, m_rv = 0;
  longint m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ipi = 0; m_tmr = 0; m_warn = 0; m_err = 0; m_unsup = 0; m_rv = 0; m_rd = 0;
    end else begin
      int s, c, tc, wd;
      s = 0; c = 0; tc = 0; wd = int'(acc_wdata);
      m_err = 0; m_unsup = 0;
      m_rv = (acc_valid && !acc_write) ? 1 : 0;
      m_rd = 0;
      if (m_rv == 1) begin
        if (acc_addr == 2'd0) m_rd = longint'(acc_cpu);
        else if (acc_addr == 2'd2) m_rd = m_ipi;
        else if (acc_addr == 2'd3) m_rd = m_tmr;
      end
      if (acc_valid && acc_write) begin
        case (acc_addr)
          2'd0: begin
            s = (wd >> 12) & VM; c = (wd >> 8) & VM; tc = (wd >> 4) & VM;
            m_unsup = (s == 0 && c == 0 && tc == 0 && ((wd >> 28) & 1) == 0) ? 1 : 0;
          end
          2'd1: begin s = wd & VM;  m_err = (s == 0) ? 1 : 0; end
          2'd2: begin c = wd & VM;  m_err = (c == 0) ? 1 : 0; end
          default: begin tc = wd & VM; m_err = (tc == 0) ? 1 : 0; end
        endcase
      end
      m_warn = (((s & m_ipi) != 0) || ((c & ~(m_ipi | s) & VM) != 0)) ? 1 : 0;
      m_ipi  = (m_ipi | s) & ~c & VM;
      m_tmr  = tick ? VM : (m_tmr & ~tc & VM);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(ipi_irq) == m_ipi,   "R2 ipi_irq vs model", ipi_irq, m_ipi);
      chk(int'(tmr_irq) == m_tmr,   "R4 tmr_irq vs model", tmr_irq, m_tmr);
      chk(int'(warn_pulse) == m_warn, "R3 warn_pulse vs model", warn_pulse, m_warn);
      chk(int'(err_pulse) == m_err, "R8 err_pulse vs model", err_pulse, m_err);
      chk(int'(unsup_pulse) == m_unsup, "R6 unsup_pulse vs model", unsup_pulse, m_unsup);
      chk(int'(rd_valid) == m_rv,   "R9 rd_valid vs model", rd_valid, m_rv);
      chk(longint'(rd_data) == m_rd, "R9 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic acc(input bit w, input logic [1:0] a, input logic [31:0] d,
                     input logic [1:0] cpu, input bit tk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d; acc_cpu = cpu; tick = tk;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    acc(1'b1, a, d, 2'd0, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ipi_irq == 0 && tmr_irq == 0, "R1 flags after reset", {ipi_irq, tmr_irq}, 0);
    chk(!warn_pulse && !err_pulse && !unsup_pulse && !rd_valid, "R1 pulses after reset",
        {warn_pulse, err_pulse, unsup_pulse, rd_valid}, 0);

    wr(2'd1, 32'h5);
    chk(ipi_irq == 3'b101, "R7 post via index 1", ipi_irq, 3'b101);
    wr(2'd1, 32'h1);
    chk(warn_pulse && ipi_irq == 3'b101, "R3 duplicate post", {warn_pulse, ipi_irq}, 4'b1101);
    wr(2'd2, 32'h4);
    chk(ipi_irq == 3'b001, "R7 drop via index 2", ipi_irq, 3'b001);
    wr(2'd2, 32'h4);
    chk(warn_pulse && ipi_irq == 3'b001, "R3 drop not pending", {warn_pulse, ipi_irq}, 4'b1001);
    wr(2'd1, 32'h0);
    chk(err_pulse, "R8 empty selection", err_pulse, 1);
    wr(2'd2, 32'h8);
    chk(err_pulse && ipi_irq == 3'b001, "R10 CPU above count is empty", {err_pulse, ipi_irq}, 4'b1001);

    acc(1'b0, 2'd0, 0, 2'd0, 1'b1);
    chk(tmr_irq == 3'b111, "R4 tick sets all", tmr_irq, 3'b111);
    wr(2'd0, 32'h0020);
    chk(tmr_irq == 3'b101, "R5 timer drop selected", tmr_irq, 3'b101);
    wr(2'd0, 32'h0020);
    chk(tmr_irq == 3'b101 && !warn_pulse, "R5 drop not pending no warn", {warn_pulse, tmr_irq}, 4'b0101);
    wr(2'd3, 32'h1);
    chk(tmr_irq == 3'b100, "R7 drop via index 3", tmr_irq, 3'b100);
    acc(1'b1, 2'd3, 32'h7, 2'd0, 1'b1);
    chk(tmr_irq == 3'b111, "R4 tick beats same-cycle drop", tmr_irq, 3'b111);

    wr(2'd0, 32'h6310);
    chk(ipi_irq == 3'b100 && tmr_irq == 3'b110 && !warn_pulse, "R2 combined control write",
        {warn_pulse, ipi_irq, tmr_irq}, 7'b0100110);

    wr(2'd0, 32'h1000_0000);
    chk(!unsup_pulse, "R6 bit 28 accepted", unsup_pulse, 0);
    wr(2'd0, 32'h0);
    chk(unsup_pulse, "R6 empty control write", unsup_pulse, 1);
    wr(2'd0, 32'h8880);
    chk(unsup_pulse && ipi_irq == 3'b100, "R10 control fields above count", {unsup_pulse, ipi_irq}, 4'b1100);

    acc(1'b0, 2'd0, 0, 2'd2, 1'b0);
    chk(rd_valid && rd_data == 2, "R9 control read cpu id", rd_data, 2);
    acc(1'b0, 2'd2, 0, 2'd1, 1'b0);
    chk(rd_valid && rd_data == DW'(ipi_irq), "R11 ipi status equals level", rd_data, ipi_irq);
    acc(1'b0, 2'd3, 0, 2'd3, 1'b0);
    chk(rd_valid && rd_data == DW'(tmr_irq), "R11 timer status equals level", rd_data, tmr_irq);
    acc(1'b0, 2'd1, 0, 2'd1, 1'b0);
    chk(rd_valid && rd_data == 0, "R9 index 1 reads zero", rd_data, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = d & 32'h1000_0007;
      acc_valid = ($urandom_range(0, 3) != 0);
      acc_write = ($urandom_range(0, 2) != 0);
      acc_addr  = 2'($urandom_range(0, 3));
      acc_wdata = d;
      acc_cpu   = 2'($urandom_range(0, 3));
      tick      = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    acc_valid = 1'b0; tick = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule